// File: doc/BRIEF.md
# Multi-Mode Pulse-Width Count Timer

This block is an 8-bit counter that runs in one of three modes. As a free-running timer it wraps at 255, pulses an output and sets an overflow flag. As a reload timer it counts up to a programmed limit and toggles a square wave. In measurement mode it times an interval on an asynchronous input pin. The interval can be the high time, the low time, the period from rise to rise, or the period from fall to fall. The counting rate comes from an internal prescaler that divides the core clock by 1, 4, 16 or 32.

Each completed measurement is offered on a small valid/ready output stream and marked by a one-cycle done pulse. A capture stays on the stream, unchanged, until the consumer accepts it. A measurement that completes while an earlier capture is still waiting is discarded, so back-pressure never stalls the counter. In one-shot use the block stops after one capture and waits for an arm pulse. In continuous use it re-arms by itself. Dropping `run` returns everything to a clean waiting state.

Top module: `pwc_timer`

## Requirements
- R1: After reset, `wave_out`, `ovf_flag`, `cap_valid` and `done` are all 0.
- R2: `clk_sel` codes 0, 1, 2 and 3 give one count tick every 1, 4, 16 or 32 clock cycles. The tick phase restarts when `run` rises, and the first tick falls in the first cycle with `run` high.
- R3: With `mode` = 0 (free timer) the counter starts at 0 and advances once per tick. On the 256th tick after `run` rises it wraps, `wave_out` is high for exactly one cycle, and `ovf_flag` is set.
- R4: With `mode` = 1 (reload) `wave_out` toggles once every `reload_val`+1 ticks, starting from 0. A value of 0 toggles on every tick.
- R5: `pin_in` passes through a two-flop synchronizer, and edges are taken from the synchronized value. With one tick per clock, a capture becomes visible on `cap_valid` after the third rising clock edge that follows the pin change closing the window.
- R6: With `mode` = 2 (measure) the window is chosen by `win_sel`: 0 = high time, 1 = low time, 2 = rise to next rise, 3 = fall to next fall. The captured value is the number of ticks inside the window.
- R7: A measurement that exceeds 255 ticks captures 255 and sets `ovf_flag`. Once set, `ovf_flag` stays high while `run` is high.
- R8: With `cont` = 1, a width window (codes 0 and 1) waits again for its opening edge after each capture. A period window (codes 2 and 3) reopens on the same edge that closed it.
- R9: With `cont` = 0 the block captures once and then ignores the pin until a one-cycle `arm` pulse. After that pulse it waits for the next opening edge.
- R10: `cap_valid` holds with `cap_data` stable until a cycle with `cap_ready` high. A capture that completes while `cap_valid` is high and `cap_ready` is low is discarded. `done` pulses for one cycle together with each capture that is loaded.
- R11: With `run` low, the counter, `ovf_flag` and `wave_out` are cleared on the next edge, and measurement returns to waiting for an opening edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Enable; low clears the counter, flags and prescaler |
| mode | input | 2 | 0 free timer, 1 reload, 2 measure, 3 hold |
| clk_sel | input | 2 | Prescaler select: divide by 1, 4, 16, 32 |
| win_sel | input | 2 | Measurement window select |
| cont | input | 1 | 1 = continuous re-arm, 0 = one-shot |
| arm | input | 1 | Re-arm pulse for one-shot measurement |
| reload_val | input | 8 | Reload limit for mode 1 |
| pin_in | input | 1 | Asynchronous measured input |
| wave_out | output | 1 | Overflow pulse (mode 0) or toggle wave (mode 1) |
| ovf_flag | output | 1 | Sticky overflow / saturation flag |
| cap_valid | output | 1 | Capture stream valid |
| cap_ready | input | 1 | Capture stream ready |
| cap_data | output | 8 | Captured tick count |
| done | output | 1 | One-cycle pulse per loaded capture |

## Verification
A counter that is off by one, or a prescaler that loses phase, shows up at the ports within one timer period. It appears as a wrong edge count before the overflow pulse or the toggle, and the bench measures those counts exactly. A wrong measurement state shows up on the next capture. It appears as a wrong value, a missing value, or an extra value after a one-shot capture. Stalls in the capture stream show up at once as data changing while it waits, or as a second done pulse for a capture that should have been discarded.

// File: rtl/pwc_pkg.sv
package pwc_pkg;

  typedef enum logic [1:0] {
    MODE_TIMER   = 2'd0,
    MODE_RELOAD  = 2'd1,
    MODE_MEASURE = 2'd2,
    MODE_HOLD    = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    ST_WAIT = 2'd0,
    ST_MEAS = 2'd1,
    ST_IDLE = 2'd2
  } mst_e;

  // log2 of the prescaler divide ratio for each clk_sel code
  localparam int unsigned DIV_LOG2 [4] = '{0, 2, 4, 5};
  localparam int unsigned PRE_W = 5;

endpackage

// File: rtl/pwc_prescaler.sv
module pwc_prescaler
  import pwc_pkg::*;
#(
  parameter int W = PRE_W
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] sel,
  output logic       tick
);

  logic [W-1:0] pcnt;
  logic [W-1:0] mask;

  always_comb begin
    mask = W'((32'd1 << DIV_LOG2[sel]) - 32'd1);
    tick = run && ((pcnt & mask) == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pcnt <= '0;
    else if (!run)   pcnt <= '0;
    else             pcnt <= pcnt + 1'b1;
  end

endmodule

// File: rtl/pwc_edge_sync.sv
module pwc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);

  // chain[STAGES-1] is the synchronized level, chain[STAGES] its history
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-1:0], pin};
  end

  always_comb begin
    rise = chain[STAGES-1] & ~chain[STAGES];
    fall = ~chain[STAGES-1] & chain[STAGES];
  end

endmodule

// File: rtl/pwc_engine.sv
module pwc_engine
  import pwc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [1:0]       mode,
  input  logic [1:0]       win,
  input  logic             cont,
  input  logic             arm,
  input  logic             rise,
  input  logic             fall,
  input  logic [CNT_W-1:0] reload_val,
  output logic             wave,
  output logic             ovf,
  output logic             cap_evt,
  output logic [CNT_W-1:0] cap_val
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_sat;
  logic             at_max;
  logic             open_e;
  logic             close_e;
  logic             period_win;
  mst_e             st;

  always_comb begin
    at_max     = (cnt == CNT_MAX);
    cnt_sat    = at_max ? CNT_MAX : cnt + 1'b1;
    period_win = win[1];
    case (win)
      2'd0:    begin open_e = rise; close_e = fall; end
      2'd1:    begin open_e = fall; close_e = rise; end
      2'd2:    begin open_e = rise; close_e = rise; end
      default: begin open_e = fall; close_e = fall; end
    endcase
    cap_evt = run && (mode == MODE_MEASURE) && (st == ST_MEAS) && close_e;
    cap_val = tick ? cnt_sat : cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      st   <= ST_WAIT;
      wave <= 1'b0;
      ovf  <= 1'b0;
    end else if (!run) begin
      cnt  <= '0;
      st   <= ST_WAIT;
      wave <= 1'b0;
      ovf  <= 1'b0;
    end else begin
      case (mode)
        MODE_TIMER: begin
          wave <= tick && at_max;
          if (tick) begin
            cnt <= cnt + 1'b1;
            if (at_max) ovf <= 1'b1;
          end
        end
        MODE_RELOAD: begin
          if (tick) begin
            if (cnt == reload_val) begin
              cnt  <= '0;
              wave <= ~wave;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        MODE_MEASURE: begin
          wave <= 1'b0;
          case (st)
            ST_WAIT: begin
              if (open_e) begin
                cnt <= '0;
                st  <= ST_MEAS;
              end
            end
            ST_MEAS: begin
              if (tick && at_max) ovf <= 1'b1;
              if (close_e) begin
                cnt <= '0;
                if (!cont)            st <= ST_IDLE;
                else if (!period_win) st <= ST_WAIT;
              end else if (tick) begin
                cnt <= cnt_sat;
              end
            end
            ST_IDLE: begin
              if (arm) st <= ST_WAIT;
            end
            default: st <= ST_WAIT;
          endcase
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/pwc_cap_port.sv
module pwc_cap_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         evt,
  input  logic [W-1:0] val,
  input  logic         ready,
  output logic         valid,
  output logic [W-1:0] data,
  output logic         done
);

  logic load;

  assign load = evt && (!valid || ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
      done  <= 1'b0;
    end else begin
      done <= load;
      if (load) begin
        valid <= 1'b1;
        data  <= val;
      end else if (valid && ready) begin
        valid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/pwc_timer.sv
module pwc_timer
  import pwc_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [1:0]       mode,
  input  logic [1:0]       clk_sel,
  input  logic [1:0]       win_sel,
  input  logic             cont,
  input  logic             arm,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             pin_in,
  output logic             wave_out,
  output logic             ovf_flag,
  output logic             cap_valid,
  input  logic             cap_ready,
  output logic [CNT_W-1:0] cap_data,
  output logic             done
);

  logic             tick;
  logic             rise;
  logic             fall;
  logic             cap_evt;
  logic [CNT_W-1:0] cap_val;

  pwc_prescaler #(.W(PRE_W)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .sel   (clk_sel),
    .tick  (tick)
  );

  pwc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .pin   (pin_in),
    .rise  (rise),
    .fall  (fall)
  );

  pwc_engine #(.CNT_W(CNT_W)) u_eng (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .tick       (tick),
    .mode       (mode),
    .win        (win_sel),
    .cont       (cont),
    .arm        (arm),
    .rise       (rise),
    .fall       (fall),
    .reload_val (reload_val),
    .wave       (wave_out),
    .ovf        (ovf_flag),
    .cap_evt    (cap_evt),
    .cap_val    (cap_val)
  );

  pwc_cap_port #(.W(CNT_W)) u_cap (
    .clk   (clk),
    .rst_n (rst_n),
    .evt   (cap_evt),
    .val   (cap_val),
    .ready (cap_ready),
    .valid (cap_valid),
    .data  (cap_data),
    .done  (done)
  );

endmodule

// File: rtl/pwc_timer_chk.sv
module pwc_timer_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic [1:0]       mode,
  input logic             wave_out,
  input logic             ovf_flag,
  input logic             cap_valid,
  input logic             cap_ready,
  input logic [CNT_W-1:0] cap_data,
  input logic             done
);

  // R10
  cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_valid && !cap_ready |=> cap_valid && $stable(cap_data));

  // R10
  done_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cap_valid);

  // R11
  stop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !ovf_flag && !wave_out);

  // R7
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag && run |=> ovf_flag);

  // R3
  timer_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wave_out && run && (mode == 2'd0) |=> !wave_out);

endmodule

bind pwc_timer pwc_timer_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_pwc_timer.sv
module tb_pwc_timer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [1:0] clk_sel = 2'd0;
  logic [1:0] win_sel = 2'd0;
  logic       cont = 1'b0;
  logic       arm = 1'b0;
  logic [7:0] reload_val = 8'd0;
  logic       pin_in = 1'b0;
  logic       cap_ready = 1'b1;
  logic       wave_out;
  logic       ovf_flag;
  logic       cap_valid;
  logic [7:0] cap_data;
  logic       done;

  int n_chk = 0;
  int n_bad = 0;
  int done_n = 0;
  int cap_q[$];

  always #10 clk = ~clk;

  pwc_timer dut (
    .clk(clk), .rst_n(rst_n), .run(run), .mode(mode), .clk_sel(clk_sel),
    .win_sel(win_sel), .cont(cont), .arm(arm), .reload_val(reload_val),
    .pin_in(pin_in), .wave_out(wave_out), .ovf_flag(ovf_flag),
    .cap_valid(cap_valid), .cap_ready(cap_ready), .cap_data(cap_data),
    .done(done)
  );

  // handshake and done monitor: values before the edge are the ones the design uses
  always @(posedge clk) begin
    if (rst_n) begin
      if (done) done_n++;
      if (cap_valid && cap_ready) cap_q.push_back(int'(cap_data));
    end
  end

  task automatic check_eq(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  task automatic configure(input logic [1:0] m, input logic [1:0] w,
                           input logic [1:0] s, input logic c);
    run = 1'b0;
    pin_in = 1'b0;
    repeat (4) @(negedge clk);
    mode = m; win_sel = w; clk_sel = s; cont = c;
    cap_q.delete();
    run = 1'b1;
  endtask

  task automatic drive(input logic v, input int n);
    pin_in = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic settle();
    pin_in = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic edges_to_change(output int n);
    logic w0;
    w0 = wave_out;
    n = 0;
    while (n < 20000) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (wave_out != w0) break;
    end
  endtask

  task automatic t_reset();
    check_eq("R1 wave_out", int'(wave_out), 0);
    check_eq("R1 ovf_flag", int'(ovf_flag), 0);
    check_eq("R1 cap_valid", int'(cap_valid), 0);
    check_eq("R1 done", int'(done), 0);
  endtask

  task automatic t_timer(input logic [1:0] s, input int exp_n, input string tag);
    int n;
    configure(2'd0, 2'd0, s, 1'b0);
    edges_to_change(n);
    check_eq({tag, " edges to overflow pulse"}, n, exp_n);
    check_eq("R3 ovf_flag after wrap", int'(ovf_flag), 1);
    @(negedge clk);
    check_eq("R3 pulse is one cycle", int'(wave_out), 0);
  endtask

  task automatic t_stop_clear();
    run = 1'b0;
    @(negedge clk);
    check_eq("R11 ovf cleared by run low", int'(ovf_flag), 0);
    check_eq("R11 wave cleared by run low", int'(wave_out), 0);
  endtask

  task automatic t_reload(input logic [7:0] r);
    int n;
    reload_val = r;
    configure(2'd1, 2'd0, 2'd0, 1'b0);
    edges_to_change(n);
    check_eq("R4 first toggle", n, int'(r) + 1);
    edges_to_change(n);
    check_eq("R4 second toggle", n, int'(r) + 1);
  endtask

  task automatic t_high_latency();
    configure(2'd2, 2'd0, 2'd0, 1'b0);
    drive(1'b0, 3);
    drive(1'b1, 17);
    pin_in = 1'b0;
    @(negedge clk);
    check_eq("R5 no capture one edge after", int'(cap_valid), 0);
    @(negedge clk);
    check_eq("R5 no capture two edges after", int'(cap_valid), 0);
    @(negedge clk);
    check_eq("R5 capture after third edge", int'(cap_valid), 1);
    check_eq("R6 high width value", int'(cap_data), 17);
    settle();
  endtask

  task automatic t_low_cont();
    configure(2'd2, 2'd1, 2'd0, 1'b1);
    drive(1'b1, 5); drive(1'b0, 7); drive(1'b1, 4); drive(1'b0, 12); drive(1'b1, 6);
    settle();
    check_eq("R8 low width capture count", cap_q.size(), 2);
    if (cap_q.size() == 2) begin
      check_eq("R6 low width first", cap_q[0], 7);
      check_eq("R6 low width second", cap_q[1], 12);
    end
  endtask

  task automatic t_rise_cont();
    configure(2'd2, 2'd2, 2'd0, 1'b1);
    drive(1'b1, 4); drive(1'b0, 6); drive(1'b1, 8); drive(1'b0, 12);
    drive(1'b1, 3); drive(1'b0, 5);
    settle();
    check_eq("R8 rise period capture count", cap_q.size(), 2);
    if (cap_q.size() == 2) begin
      check_eq("R6 rise period first", cap_q[0], 10);
      check_eq("R8 rise period shared edge", cap_q[1], 20);
    end
  endtask

  task automatic t_fall_cont();
    configure(2'd2, 2'd3, 2'd0, 1'b1);
    drive(1'b1, 3); drive(1'b0, 9); drive(1'b1, 5); drive(1'b0, 6);
    drive(1'b1, 4); drive(1'b0, 4);
    settle();
    check_eq("R8 fall period capture count", cap_q.size(), 2);
    if (cap_q.size() == 2) begin
      check_eq("R6 fall period first", cap_q[0], 14);
      check_eq("R8 fall period shared edge", cap_q[1], 10);
    end
  endtask

  task automatic t_saturate();
    configure(2'd2, 2'd0, 2'd0, 1'b0);
    drive(1'b1, 300);
    settle();
    check_eq("R7 saturated capture", cap_q.size() > 0 ? cap_q[0] : -1, 255);
    check_eq("R7 ovf_flag on saturation", int'(ovf_flag), 1);
    t_stop_clear();
  endtask

  task automatic t_div4();
    configure(2'd2, 2'd0, 2'd1, 1'b0);
    drive(1'b1, 40);
    settle();
    check_eq("R2 divide-by-4 width", cap_q.size() > 0 ? cap_q[0] : -1, 10);
  endtask

  task automatic t_oneshot();
    configure(2'd2, 2'd0, 2'd0, 1'b0);
    drive(1'b1, 6); settle();
    drive(1'b1, 9); settle();
    check_eq("R9 one capture before arm", cap_q.size(), 1);
    arm = 1'b1;
    @(negedge clk);
    arm = 1'b0;
    drive(1'b1, 11); settle();
    check_eq("R9 capture after arm count", cap_q.size(), 2);
    if (cap_q.size() == 2) begin
      check_eq("R9 first one-shot value", cap_q[0], 6);
      check_eq("R9 value after arm", cap_q[1], 11);
    end
  endtask

  task automatic t_backpressure();
    int d0;
    configure(2'd2, 2'd2, 2'd0, 1'b1);
    cap_ready = 1'b0;
    d0 = done_n;
    drive(1'b1, 4); drive(1'b0, 6); drive(1'b1, 8); drive(1'b0, 12);
    drive(1'b1, 3); drive(1'b0, 5);
    check_eq("R10 valid held", int'(cap_valid), 1);
    check_eq("R10 first capture kept", int'(cap_data), 10);
    check_eq("R10 one done for dropped pair", done_n - d0, 1);
    cap_ready = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check_eq("R10 valid drops after accept", int'(cap_valid), 0);
    check_eq("R10 accepted value", cap_q.size() > 0 ? cap_q[0] : -1, 10);
    settle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_timer(2'd0, 256, "R3 div1");
    t_stop_clear();
    t_timer(2'd1, 1021, "R2 div4");
    t_timer(2'd3, 8161, "R2 div32");
    t_reload(8'd5);
    t_reload(8'd0);
    t_high_latency();
    t_low_cont();
    t_rise_cont();
    t_fall_cont();
    t_saturate();
    t_div4();
    t_oneshot();
    t_backpressure();
    finish_up();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_up();
  end

endmodule